// File: doc/BRIEF.md
# Snooping MESI Cache Coherence Controller

This block keeps one private, direct-mapped cache coherent with its peers in a small multicore system. Each line holds one data word, an address tag and one of four coherence states: Invalid, Shared, Exclusive or Modified. The controller serves loads and stores from its CPU port. Misses, upgrades and dirty-victim writebacks go out as transactions on a shared snooping bus. A single responder outside the block completes each transaction with an acknowledge, returned data and a shared indication. That responder stands for both the peer caches and main memory.

The controller also watches a second, independent input stream: the transactions that peer caches place on the bus. Each snooped transaction is looked up in the local array in the cycle it arrives. A one-cycle response follows. It reports whether the line is held, supplies the line directly to the requester when it is held, and flags dirty data that memory must absorb. The local line state is adjusted so that at most one cache can write a line at a time.

Snoops and CPU accesses are accepted concurrently. When both touch the same array index in one cycle, the snoop is ordered first.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_done_o`, `bus_req_o` and `snp_resp_o` are low.
- R2: A load that hits a valid line returns its data with `cpu_done_o` high in the cycle after acceptance, with no bus transaction; `cpu_done_o` is a single-cycle pulse.
- R3: A load miss issues bus command RD (`bus_cmd_o`=0) at the requested address and returns `bus_rdata_i`. The line is filled Exclusive when `bus_shared_i` is low at the acknowledge, and Shared when it is high.
- R4: A store miss issues command RFO (1) and fills the line as Modified with the store data. A later load to it hits without bus traffic.
- R5: A store that hits an Exclusive or Modified line writes the data and leaves the line Modified, with no bus transaction.
- R6: A store that hits a Shared line first issues command INV (2) at its address. After the acknowledge the line becomes Modified with the store data.
- R7: A snooped RD (`snp_cmd_i`=0) that hits an Exclusive or Shared line responds in the next cycle with shared=1, supply=1, dirty=0 and the line data. The local line ends Shared.
- R8: A snooped RD that hits a Modified line responds with shared=1, supply=1, dirty=1 and the dirty data. The local line ends Shared.
- R9: A snooped RFO (1) or INV (2) that hits a valid line makes it Invalid. RFO always supplies the data. INV supplies it only if the line was Modified. The dirty flag is set exactly when the line was Modified.
- R10: A snooped WB (3), or any snoop that misses (Invalid line or other tag), responds with shared, supply and dirty all 0 and leaves the line unchanged.
- R11: A miss whose victim (same index, low 3 address bits by default) is Modified first issues command WB (3) with the victim's address and data, then the fill request. A clean victim is dropped with no bus transaction.
- R12: When a snoop and a CPU access target the same index in one cycle, the snoop takes effect first. A store to a Shared line that meets a snooped RFO to that line completes as a miss issuing RFO, not INV.
- R13: Once raised, `bus_req_o` stays high with stable command, address and write data until `bus_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | CPU access request, held until done |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Word address of the access |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Load data, valid with done |
| bus_req_o | output | 1 | Bus transaction pending |
| bus_cmd_o | output | 2 | RD=0, RFO=1, INV=2, WB=3 |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Writeback data |
| bus_ack_i | input | 1 | Transaction complete |
| bus_rdata_i | input | DATA_W | Fill data, valid with ack |
| bus_shared_i | input | 1 | A peer holds the line, valid with ack |
| snp_valid_i | input | 1 | Peer transaction observed |
| snp_cmd_i | input | 2 | Observed command, same encoding |
| snp_addr_i | input | ADDR_W | Observed address |
| snp_resp_o | output | 1 | Snoop response valid (one cycle later) |
| snp_shared_o | output | 1 | Line held locally |
| snp_supply_o | output | 1 | Data is being supplied |
| snp_dirty_o | output | 1 | Supplied data is dirty, memory must take it |
| snp_data_o | output | DATA_W | Supplied line data |

## Verification
The CPU lookup and a snooped transaction can hit the same array index in one cycle. The case that matters is a store to a Shared line arriving together with a peer's read-for-ownership of that line. The bench provokes it by raising the CPU store and the snooped RFO on the same clock edge. It judges the outcome in three places: the snoop response (data supplied, not dirty), the CPU's following bus traffic (a single RFO and no INV), and a later snooped read that must see the new data as dirty.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_RFO = 2'd1,
    CMD_INV = 2'd2,
    CMD_WB  = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // port a: cpu side
  input  logic [IDX_W-1:0]  a_idx_i,
  output mesi_t             a_state_o,
  output logic [TAG_W-1:0]  a_tag_o,
  output logic [DATA_W-1:0] a_data_o,
  input  logic              cw_en_i,
  input  mesi_t             cw_state_i,
  input  logic [TAG_W-1:0]  cw_tag_i,
  input  logic [DATA_W-1:0] cw_data_i,
  // port b: snoop side
  input  logic [IDX_W-1:0]  b_idx_i,
  output mesi_t             b_state_o,
  output logic [TAG_W-1:0]  b_tag_o,
  output logic [DATA_W-1:0] b_data_o,
  input  logic              sw_en_i,
  input  mesi_t             sw_state_i
);
  localparam int LINES = 1 << IDX_W;

  mesi_t             st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  assign a_state_o = st_q[a_idx_i];
  assign a_tag_o   = tag_q[a_idx_i];
  assign a_data_o  = data_q[a_idx_i];
  assign b_state_o = st_q[b_idx_i];
  assign b_tag_o   = tag_q[b_idx_i];
  assign b_data_o  = data_q[b_idx_i];

  // snoop update lands first; a cpu write to the same line overrides it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (cw_en_i && a_idx_i == IDX_W'(i)) begin
          st_q[i]   <= cw_state_i;
          tag_q[i]  <= cw_tag_i;
          data_q[i] <= cw_data_i;
        end else if (sw_en_i && b_idx_i == IDX_W'(i)) begin
          st_q[i] <= sw_state_i;
        end
      end
    end
  end

  assert_snoop_update_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_i && !(cw_en_i && a_idx_i == b_idx_i)) |=> st_q[$past(b_idx_i)] == $past(sw_state_i));

  assert_cpu_write_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cw_en_i && sw_en_i && a_idx_i == b_idx_i) |=> st_q[$past(a_idx_i)] == $past(cw_state_i));
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snp_valid_i,
  input  bus_cmd_t          snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic [IDX_W-1:0]  line_idx_o,
  input  mesi_t             line_state_i,
  input  logic [ADDR_W-IDX_W-1:0] line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              sw_en_o,
  output mesi_t             sw_state_o,
  output logic              resp_o,
  output logic              shared_o,
  output logic              supply_o,
  output logic              dirty_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic hit, is_m;
  logic shared_d, supply_d, dirty_d;

  assign line_idx_o = snp_addr_i[IDX_W-1:0];
  assign hit  = snp_valid_i && (line_state_i != ST_I) &&
                (line_tag_i == snp_addr_i[ADDR_W-1:IDX_W]);
  assign is_m = (line_state_i == ST_M);

  always_comb begin
    shared_d   = 1'b0;
    supply_d   = 1'b0;
    dirty_d    = 1'b0;
    sw_en_o    = 1'b0;
    sw_state_o = line_state_i;
    if (hit) begin
      unique case (snp_cmd_i)
        CMD_RD: begin
          shared_d   = 1'b1;
          supply_d   = 1'b1;
          dirty_d    = is_m;
          sw_en_o    = (line_state_i != ST_S);
          sw_state_o = ST_S;
        end
        CMD_RFO: begin
          supply_d   = 1'b1;
          dirty_d    = is_m;
          sw_en_o    = 1'b1;
          sw_state_o = ST_I;
        end
        CMD_INV: begin
          supply_d   = is_m;
          dirty_d    = is_m;
          sw_en_o    = 1'b1;
          sw_state_o = ST_I;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_o   <= 1'b0;
      shared_o <= 1'b0;
      supply_o <= 1'b0;
      dirty_o  <= 1'b0;
      data_o   <= '0;
    end else begin
      resp_o   <= snp_valid_i;
      shared_o <= shared_d;
      supply_o <= supply_d;
      dirty_o  <= dirty_d;
      data_o   <= supply_d ? line_data_i : '0;
    end
  end

  assert_dirty_supplies_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_o |-> supply_o);

  assert_resp_follows_snoop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o |-> $past(snp_valid_i));

  assert_wb_snoop_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == CMD_WB) |=> !shared_o && !supply_o && !dirty_o);

  assert_no_tag_mismatch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && line_tag_i != snp_addr_i[ADDR_W-1:IDX_W]) |-> !sw_en_o);

  logic unused_tagw;
  assign unused_tagw = (TAG_W == 0);
endmodule

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output bus_cmd_t          bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  input  logic              conflict_i,
  output logic [IDX_W-1:0]  line_idx_o,
  input  mesi_t             line_state_i,
  input  logic [ADDR_W-IDX_W-1:0] line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              cw_en_o,
  output mesi_t             cw_state_o,
  output logic [ADDR_W-IDX_W-1:0] cw_tag_o,
  output logic [DATA_W-1:0] cw_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {F_IDLE, F_WB, F_REQ} fsm_t;

  fsm_t              fs_q, fs_d;
  logic [ADDR_W-1:0] addr_q, vic_addr_q;
  logic [DATA_W-1:0] wdata_q, vic_data_q, rdata_q, rdata_d;
  logic              we_q, done_q, done_d;
  bus_cmd_t          cmd_q, cmd_d;
  logic              take, save_vic;

  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  cur_tag;
  logic              hit, accept;

  assign cur_addr   = (fs_q == F_IDLE) ? cpu_addr_i : addr_q;
  assign cur_tag    = cur_addr[ADDR_W-1:IDX_W];
  assign line_idx_o = cur_addr[IDX_W-1:0];
  assign hit        = (line_state_i != ST_I) && (line_tag_i == cur_tag);
  assign accept     = (fs_q == F_IDLE) && cpu_req_i && !done_q && !conflict_i;

  always_comb begin
    fs_d       = fs_q;
    cmd_d      = cmd_q;
    done_d     = 1'b0;
    rdata_d    = rdata_q;
    take       = 1'b0;
    save_vic   = 1'b0;
    cw_en_o    = 1'b0;
    cw_state_o = line_state_i;
    cw_tag_o   = line_tag_i;
    cw_data_o  = line_data_i;
    unique case (fs_q)
      F_IDLE: if (accept) begin
        take = 1'b1;
        if (hit) begin
          if (!cpu_we_i) begin
            done_d  = 1'b1;
            rdata_d = line_data_i;
          end else if (line_state_i == ST_S) begin
            cmd_d = CMD_INV;
            fs_d  = F_REQ;
          end else begin
            cw_en_o    = 1'b1;
            cw_state_o = ST_M;
            cw_data_o  = cpu_wdata_i;
            done_d     = 1'b1;
          end
        end else begin
          cmd_d = cpu_we_i ? CMD_RFO : CMD_RD;
          if (line_state_i == ST_M) begin
            save_vic = 1'b1;
            fs_d     = F_WB;
          end else begin
            fs_d = F_REQ;
          end
        end
      end
      F_WB: if (bus_ack_i) begin
        cw_en_o    = 1'b1;
        cw_state_o = ST_I;
        fs_d       = F_REQ;
      end
      F_REQ: if (bus_ack_i) begin
        fs_d = F_IDLE;
        unique case (cmd_q)
          CMD_INV: begin
            // upgrade only if the shared copy survived every snoop so far
            if (!conflict_i && hit && line_state_i == ST_S) begin
              cw_en_o    = 1'b1;
              cw_state_o = ST_M;
              cw_data_o  = wdata_q;
              done_d     = 1'b1;
            end
          end
          CMD_RFO: begin
            cw_en_o    = 1'b1;
            cw_state_o = ST_M;
            cw_tag_o   = cur_tag;
            cw_data_o  = wdata_q;
            done_d     = 1'b1;
          end
          default: begin
            cw_en_o    = 1'b1;
            cw_state_o = bus_shared_i ? ST_S : ST_E;
            cw_tag_o   = cur_tag;
            cw_data_o  = bus_rdata_i;
            done_d     = 1'b1;
            rdata_d    = bus_rdata_i;
          end
        endcase
      end
      default: fs_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q       <= F_IDLE;
      cmd_q      <= CMD_RD;
      addr_q     <= '0;
      wdata_q    <= '0;
      we_q       <= 1'b0;
      vic_addr_q <= '0;
      vic_data_q <= '0;
      done_q     <= 1'b0;
      rdata_q    <= '0;
    end else begin
      fs_q    <= fs_d;
      cmd_q   <= cmd_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
      if (take) begin
        addr_q  <= cpu_addr_i;
        wdata_q <= cpu_wdata_i;
        we_q    <= cpu_we_i;
      end
      if (save_vic) begin
        vic_addr_q <= {line_tag_i, cpu_addr_i[IDX_W-1:0]};
        vic_data_q <= line_data_i;
      end
    end
  end

  assign cpu_done_o  = done_q;
  assign cpu_rdata_o = rdata_q;
  assign bus_req_o   = (fs_q != F_IDLE);
  assign bus_cmd_o   = (fs_q == F_WB) ? CMD_WB : cmd_q;
  assign bus_addr_o  = (fs_q == F_WB) ? vic_addr_q : addr_q;
  assign bus_wdata_o = (fs_q == F_WB) ? vic_data_q : wdata_q;

  assert_bus_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> bus_req_o && $stable(bus_cmd_o) &&
                                  $stable(bus_addr_o) && $stable(bus_wdata_o));

  assert_owned_store_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cpu_we_i && hit && line_state_i != ST_S) |=> !bus_req_o && cpu_done_o);

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> !cpu_done_o);

  assert_wb_then_fill_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_q == F_WB && bus_ack_i) |=> bus_req_o && bus_cmd_o != CMD_WB);

  assert_store_cmd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cmd_o == CMD_RD) |-> !we_q);

  assert_snoop_first_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_q == F_IDLE && conflict_i) |=> !bus_req_o && !cpu_done_o);
endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_resp_o,
  output logic              snp_shared_o,
  output logic              snp_supply_o,
  output logic              snp_dirty_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx;
  mesi_t             a_state, b_state, cw_state, sw_state;
  logic [TAG_W-1:0]  a_tag, b_tag, cw_tag;
  logic [DATA_W-1:0] a_data, b_data, cw_data;
  logic              cw_en, sw_en, conflict;
  bus_cmd_t          bus_cmd;

  assign conflict  = snp_valid_i && (b_idx == a_idx);
  assign bus_cmd_o = bus_cmd;

  mesi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_idx_i    (a_idx),
    .a_state_o  (a_state),
    .a_tag_o    (a_tag),
    .a_data_o   (a_data),
    .cw_en_i    (cw_en),
    .cw_state_i (cw_state),
    .cw_tag_i   (cw_tag),
    .cw_data_i  (cw_data),
    .b_idx_i    (b_idx),
    .b_state_o  (b_state),
    .b_tag_o    (b_tag),
    .b_data_o   (b_data),
    .sw_en_i    (sw_en),
    .sw_state_i (sw_state)
  );

  mesi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .snp_valid_i  (snp_valid_i),
    .snp_cmd_i    (bus_cmd_t'(snp_cmd_i)),
    .snp_addr_i   (snp_addr_i),
    .line_idx_o   (b_idx),
    .line_state_i (b_state),
    .line_tag_i   (b_tag),
    .line_data_i  (b_data),
    .sw_en_o      (sw_en),
    .sw_state_o   (sw_state),
    .resp_o       (snp_resp_o),
    .shared_o     (snp_shared_o),
    .supply_o     (snp_supply_o),
    .dirty_o      (snp_dirty_o),
    .data_o       (snp_data_o)
  );

  mesi_cpu_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_cpu (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_req_i    (cpu_req_i),
    .cpu_we_i     (cpu_we_i),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_done_o   (cpu_done_o),
    .cpu_rdata_o  (cpu_rdata_o),
    .bus_req_o    (bus_req_o),
    .bus_cmd_o    (bus_cmd),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_ack_i    (bus_ack_i),
    .bus_rdata_i  (bus_rdata_i),
    .bus_shared_i (bus_shared_i),
    .conflict_i   (conflict),
    .line_idx_o   (a_idx),
    .line_state_i (a_state),
    .line_tag_i   (a_tag),
    .line_data_i  (a_data),
    .cw_en_o      (cw_en),
    .cw_state_o   (cw_state),
    .cw_tag_o     (cw_tag),
    .cw_data_o    (cw_data)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !cpu_done_o && !bus_req_o && !snp_resp_o);
endmodule

// File: tb/tb_mesi_cache_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_cache_ctrl;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [1:0] RD = 2'd0, RFO = 2'd1, INV = 2'd2, WB = 2'd3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_ack = 0, bus_shared = 0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_resp, snp_shared, snp_supply, snp_dirty;
  logic [DW-1:0] snp_data;

  int checks = 0, fails = 0;
  int ack_delay = 0;
  int nbus, niter;
  logic [1:0]    lcmd [4];
  logic [AW-1:0] laddr[4];
  logic [DW-1:0] lwd  [4];
  logic [3:0]    conf_resp;
  logic [DW-1:0] rd;

  always #10 clk = ~clk;

  mesi_cache_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata), .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .snp_resp_o(snp_resp), .snp_shared_o(snp_shared), .snp_supply_o(snp_supply),
    .snp_dirty_o(snp_dirty), .snp_data_o(snp_data)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one CPU access; serves the bus as memory/peers and logs every transaction
  task automatic cpu_access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                            input logic shr, input logic [DW-1:0] mem, input logic conf_rfo);
    int waited = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    if (conf_rfo) begin snp_valid = 1; snp_cmd = RFO; snp_addr = a; end
    nbus = 0; niter = 0;
    forever begin
      @(negedge clk);
      niter++;
      bus_ack = 0;
      if (conf_rfo && niter == 1) begin
        snp_valid = 0;
        conf_resp = {snp_resp, snp_shared, snp_supply, snp_dirty};
      end
      if (cpu_done) begin
        rd = cpu_rdata;
        cpu_req = 0;
        break;
      end
      if (bus_req) begin
        if (waited >= ack_delay) begin
          if (nbus < 4) begin
            lcmd[nbus] = bus_cmd; laddr[nbus] = bus_addr; lwd[nbus] = bus_wdata;
          end
          nbus++;
          bus_ack = 1; bus_rdata = mem; bus_shared = shr;
          waited = 0;
        end else waited++;
      end
      if (niter > 200) begin
        fails++; checks++;
        $display("FAIL cpu access hang: actual %0d expected <200", niter);
        cpu_req = 0;
        break;
      end
    end
  endtask

  task automatic snoop_chk(input string req, input logic [1:0] cmd, input logic [AW-1:0] a,
                           input logic [3:0] exp_flags, input logic [DW-1:0] exp_data);
    @(negedge clk);
    snp_valid = 1; snp_cmd = cmd; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    check({req, " snoop flags {resp,shared,supply,dirty}"},
          DW'({snp_resp, snp_shared, snp_supply, snp_dirty}), DW'(exp_flags));
    if (exp_flags[1]) check({req, " snoop data"}, snp_data, exp_data);
  endtask

  task automatic t_reset;
    check("R1 done low", DW'(cpu_done), 0);
    check("R1 bus_req low", DW'(bus_req), 0);
    check("R1 snp_resp low", DW'(snp_resp), 0);
    snoop_chk("R1 all invalid", RD, 16'h0005, 4'b1000, '0);
  endtask

  task automatic t_excl_flow;
    cpu_access(0, 16'h0011, '0, 0, 32'hAAAA_0001, 0);
    check("R3 rd miss bus count", nbus, 1);
    check("R3 rd miss cmd", DW'(lcmd[0]), DW'(RD));
    check("R3 rd miss addr", DW'(laddr[0]), 32'h11);
    check("R3 rd miss data", rd, 32'hAAAA_0001);
    cpu_access(0, 16'h0011, '0, 0, 32'hDEAD_DEAD, 0);
    check("R2 hit no bus", nbus, 0);
    check("R2 hit latency", niter, 1);
    check("R2 hit data", rd, 32'hAAAA_0001);
    cpu_access(1, 16'h0011, 32'h5555, 0, '0, 0);
    check("R5 E store silent", nbus, 0);
    snoop_chk("R8 snoop rd on M", RD, 16'h0011, 4'b1111, 32'h5555);
    snoop_chk("R7 snoop rd on S", RD, 16'h0011, 4'b1110, 32'h5555);
    cpu_access(1, 16'h0011, 32'h6666, 0, '0, 0);
    check("R6 S store bus count", nbus, 1);
    check("R6 S store cmd INV", DW'(lcmd[0]), DW'(INV));
    check("R6 S store addr", DW'(laddr[0]), 32'h11);
    snoop_chk("R9 snoop inv on M", INV, 16'h0011, 4'b1011, 32'h6666);
    snoop_chk("R9 line invalid after inv", RD, 16'h0011, 4'b1000, '0);
  endtask

  task automatic t_shared_fill;
    ack_delay = 3;
    cpu_access(0, 16'h0012, '0, 1, 32'h1212_1212, 0);
    check("R13 delayed ack single txn", nbus, 1);
    check("R3 shared fill data", rd, 32'h1212_1212);
    ack_delay = 0;
    cpu_access(1, 16'h0012, 32'h77, 0, '0, 0);
    check("R3 shared fill then store cmd INV", DW'(lcmd[0]), DW'(INV));
  endtask

  task automatic t_snoop_excl;
    cpu_access(0, 16'h0013, '0, 0, 32'h1313_0000, 0);
    snoop_chk("R7 snoop rd on E", RD, 16'h0013, 4'b1110, 32'h1313_0000);
    cpu_access(1, 16'h0013, 32'h88, 0, '0, 0);
    check("R7 E dropped to S: store needs INV", DW'(lcmd[0]), DW'(INV));
  endtask

  task automatic t_store_miss;
    cpu_access(1, 16'h0014, 32'h1414_CAFE, 0, 32'h0BAD_0BAD, 0);
    check("R4 store miss count", nbus, 1);
    check("R4 store miss cmd RFO", DW'(lcmd[0]), DW'(RFO));
    check("R4 store miss addr", DW'(laddr[0]), 32'h14);
    cpu_access(0, 16'h0014, '0, 0, 32'hDEAD_DEAD, 0);
    check("R4 load after store miss no bus", nbus, 0);
    check("R4 load after store miss data", rd, 32'h1414_CAFE);
    snoop_chk("R9 snoop rfo on M", RFO, 16'h0014, 4'b1011, 32'h1414_CAFE);
    snoop_chk("R9 line invalid after rfo", RD, 16'h0014, 4'b1000, '0);
  endtask

  task automatic t_evict;
    cpu_access(1, 16'h0015, 32'h1515_0001, 0, '0, 0);
    cpu_access(0, 16'h0025, '0, 0, 32'h2525_0002, 0);
    check("R11 dirty evict count", nbus, 2);
    check("R11 first cmd WB", DW'(lcmd[0]), DW'(WB));
    check("R11 WB addr", DW'(laddr[0]), 32'h15);
    check("R11 WB data", lwd[0], 32'h1515_0001);
    check("R11 then RD", DW'(lcmd[1]), DW'(RD));
    check("R11 RD addr", DW'(laddr[1]), 32'h25);
    check("R11 fill data", rd, 32'h2525_0002);
    snoop_chk("R11 victim gone", RD, 16'h0015, 4'b1000, '0);
    cpu_access(0, 16'h0035, '0, 0, 32'h3535_0003, 0);
    check("R11 clean evict single RD", nbus, 1);
    check("R11 clean evict cmd", DW'(lcmd[0]), DW'(RD));
  endtask

  task automatic t_ignored;
    snoop_chk("R10 snooped WB ignored", WB, 16'h0035, 4'b1000, '0);
    snoop_chk("R10 other tag miss", RD, 16'h0045, 4'b1000, '0);
    cpu_access(1, 16'h0035, 32'h99, 0, '0, 0);
    check("R10 line still E: silent store", nbus, 0);
  endtask

  task automatic t_conflict;
    cpu_access(0, 16'h0016, '0, 1, 32'h1616_0000, 0);
    cpu_access(1, 16'h0016, 32'h1616_BEEF, 0, '0, 1);
    check("R12 conflicting snoop rfo on S", DW'(conf_resp), DW'(4'b1010));
    check("R12 store became miss count", nbus, 1);
    check("R12 store issued RFO", DW'(lcmd[0]), DW'(RFO));
    snoop_chk("R12 final M data", RD, 16'h0016, 4'b1111, 32'h1616_BEEF);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_excl_flow();
    t_shared_fill();
    t_snoop_excl();
    t_store_miss();
    t_evict();
    t_ignored();
    t_conflict();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule